// File: doc/BRIEF.md
# USB Endpoint Event Flag Register

This block holds the sticky event flags of a small USB device controller that has five endpoint directions: EP0 in both directions, EP1 receiving only, and EP2 and EP3 transmitting only. The serial interface engine reports finished transactions as single-cycle pulses. Each pulse sets the matching flag. A flag then stays at 1 until the CPU or a byte-count reload clears it.

A companion enable register selects which flags may raise the single CPU interrupt line, and that line is registered. Two side effects are tied to clearing. Writing an IN endpoint's byte-count register releases that endpoint's buffer-available flag. Clearing a receive-data flag sends a one-cycle arm pulse back to the engine, so the endpoint can accept its next packet.

Both registers sit on a simple address, write and read port with a 5-bit register address.

Top module: `usb_ep_event_flags`

## Requirements
- R1: After reset the flag register reads 0x19, with the EP0-IN, EP2-IN and EP3-IN buffer flags at 1 and all other flags at 0. The enable register reads 0x00. `irq` and both `out_arm` bits are 0.
- R2: A read of the flag register at address 0x07 returns its bits in this layout:
  - bit5: setup data
  - bit4: EP3-IN
  - bit3: EP2-IN
  - bit2: EP1-OUT
  - bit1: EP0-OUT
  - bit0: EP0-IN
  
  Bits 7 and 6 always read 0. The enable register at address 0x08 uses the same bit layout, and its bits 7:6 also read 0.
- R3: A pulse on `ev_setup_ok`, `ev_in_ack[k]` or `ev_out_ack[k]` sets the corresponding flag at the next rising clock edge. `ev_in_ack` bit 0 is EP0, bit 1 is EP2 and bit 2 is EP3. `ev_out_ack` bit 0 is EP0 and bit 1 is EP1.
- R4: A flag that is set holds its value while no clear source targets it.
- R5: A write to address 0x07 clears every flag whose data bit is 1 and leaves every flag whose data bit is 0 unchanged. A write to any other address never changes a flag.
- R6: A pulse on `bc_wr[k]` clears the IN buffer flag of the same endpoint. The index order of `bc_wr` is the same as for `ev_in_ack`.
- R7: When a set event and a clear, from software or from a byte-count write, reach the same flag in the same cycle, the flag ends at 1.
- R8: When a write clear takes the EP0-OUT flag (`out_arm[0]`) or the EP1-OUT flag (`out_arm[1]`) from 1 to 0, that `out_arm` bit is 1 for exactly the one cycle after the clearing edge. No pulse occurs when the flag was already 0, or when a set event in the same cycle keeps the flag at 1.
- R9: `irq` is 1 in the cycle after any flag and its enable bit are both 1, and 0 in the cycle after no such pair exists.
- R10: `reg_rdata` is 0 when `reg_rd` is 0, or when the address is neither 0x07 nor 0x08.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ev_setup_ok | input | 1 | Engine pulse: eight setup bytes received without error |
| ev_in_ack | input | 3 | Engine pulses: IN data acknowledged by the host (EP0, EP2, EP3) |
| ev_out_ack | input | 2 | Engine pulses: OUT packet received and acknowledged (EP0, EP1) |
| bc_wr | input | 3 | Byte-count register write strobes (EP0, EP2, EP3) |
| reg_addr | input | 5 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rd | input | 1 | Register read enable |
| reg_rdata | output | 8 | Register read data (combinational) |
| out_arm | output | 2 | Re-arm pulses for EP0-OUT and EP1-OUT |
| irq | output | 1 | Registered interrupt request |

## Verification
A hardware set event and a clear can reach the same flag in the same cycle. The clear may come from a write-one clear or from a byte-count strobe. The bench provokes the collision by driving the event pulse and the clear together within one vector of its table.

The bench then judges the outcome from two results. The flag read back at 1 after the edge is the first. For a receive flag, the absence of an arm pulse in that cycle is the second.

A second collision clears a receive flag by write while the other receive flag is already 0. Only the arm bit whose flag actually fell is expected to pulse.

// File: rtl/usb_evt_pkg.sv
package usb_evt_pkg;
   localparam int NUM_FLAGS = 6;
   localparam int NUM_IN    = 3;
   localparam int NUM_OUT   = 2;

   // bit positions inside the flag and enable registers
   localparam int BIT_IN0   = 0;
   localparam int BIT_OUT0  = 1;
   localparam int BIT_OUT1  = 2;
   localparam int BIT_IN2   = 3;
   localparam int BIT_IN3   = 4;
   localparam int BIT_SETUP = 5;

   localparam logic [NUM_FLAGS-1:0] FLAG_RST = 6'h19;

   localparam logic [4:0] DEF_FLAG_ADDR = 5'h07;
   localparam logic [4:0] DEF_ENA_ADDR  = 5'h08;

   typedef enum logic [1:0] {
      KIND_IN    = 2'd0,
      KIND_OUT   = 2'd1,
      KIND_PLAIN = 2'd2
   } flag_kind_e;

   function automatic flag_kind_e kind_of(int i);
      if (i == BIT_IN0 || i == BIT_IN2 || i == BIT_IN3) return KIND_IN;
      if (i == BIT_OUT0 || i == BIT_OUT1)               return KIND_OUT;
      return KIND_PLAIN;
   endfunction

   // port index of an IN flag within ev_in_ack / bc_wr
   function automatic int in_port(int i);
      if (i == BIT_IN0) return 0;
      if (i == BIT_IN2) return 1;
      return 2;
   endfunction

   // port index of an OUT flag within ev_out_ack / out_arm
   function automatic int out_port(int i);
      if (i == BIT_OUT0) return 0;
      return 1;
   endfunction
endpackage

// File: rtl/evt_flag_bit.sv
module evt_flag_bit #(
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     flag_o <= RST_VAL;
      else if (set_i) flag_o <= 1'b1;
      else if (clr_i) flag_o <= 1'b0;
   end
endmodule

// File: rtl/evt_out_flag_bit.sv
module evt_out_flag_bit #(
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic sw_clr_i,
   output logic flag_o,
   output logic arm_o
);
   evt_flag_bit #(.RST_VAL(RST_VAL)) u_bit (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (set_i),
      .clr_i  (sw_clr_i),
      .flag_o (flag_o)
   );

   // pulse only when the write really takes the flag from 1 to 0
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) arm_o <= 1'b0;
      else        arm_o <= flag_o & sw_clr_i & ~set_i;
   end
endmodule

// File: rtl/evt_enable_reg.sv
module evt_enable_reg #(
   parameter int         N      = 6,
   parameter int         ADDR_W = 5,
   parameter logic [4:0] ADDR   = 5'h08
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [N-1:0]      wdata_i,
   output logic [N-1:0]      ena_o
);
   logic hit;
   assign hit = wr_i && (addr_i == ADDR_W'(ADDR));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   ena_o <= '0;
      else if (hit) ena_o <= wdata_i;
   end
endmodule

// File: rtl/evt_irq_reduce.sv
module evt_irq_reduce #(
   parameter int N = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] flag_i,
   input  logic [N-1:0] ena_i,
   output logic         irq_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_o <= 1'b0;
      else        irq_o <= |(flag_i & ena_i);
   end
endmodule

// File: rtl/usb_ep_event_flags.sv
module usb_ep_event_flags
   import usb_evt_pkg::*;
#(
   parameter int         ADDR_W    = 5,
   parameter int         DATA_W    = 8,
   parameter logic [4:0] FLAG_ADDR = DEF_FLAG_ADDR,
   parameter logic [4:0] ENA_ADDR  = DEF_ENA_ADDR
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ev_setup_ok,
   input  logic [2:0]        ev_in_ack,
   input  logic [1:0]        ev_out_ack,
   input  logic [2:0]        bc_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic              reg_rd,
   output logic [DATA_W-1:0] reg_rdata,
   output logic [1:0]        out_arm,
   output logic              irq
);
   localparam int RSVD_W = DATA_W - NUM_FLAGS;

   if (DATA_W < NUM_FLAGS + 1) begin : g_bad_width
      $error("DATA_W too narrow for the flag layout");
   end
   if (FLAG_ADDR == ENA_ADDR) begin : g_bad_addr
      $error("flag and enable registers share an address");
   end

   logic [NUM_FLAGS-1:0] flag_q;
   logic [NUM_FLAGS-1:0] ena_q;
   logic [NUM_FLAGS-1:0] set_vec;
   logic [NUM_FLAGS-1:0] sw_clr;
   logic                 flag_wr;

   assign set_vec[BIT_IN0]   = ev_in_ack[0];
   assign set_vec[BIT_OUT0]  = ev_out_ack[0];
   assign set_vec[BIT_OUT1]  = ev_out_ack[1];
   assign set_vec[BIT_IN2]   = ev_in_ack[1];
   assign set_vec[BIT_IN3]   = ev_in_ack[2];
   assign set_vec[BIT_SETUP] = ev_setup_ok;

   assign flag_wr = reg_wr && (reg_addr == ADDR_W'(FLAG_ADDR));
   assign sw_clr  = flag_wr ? reg_wdata[NUM_FLAGS-1:0] : '0;

   for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
      if (kind_of(i) == KIND_OUT) begin : g_out
         evt_out_flag_bit #(.RST_VAL(FLAG_RST[i])) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_i    (set_vec[i]),
            .sw_clr_i (sw_clr[i]),
            .flag_o   (flag_q[i]),
            .arm_o    (out_arm[out_port(i)])
         );
      end else if (kind_of(i) == KIND_IN) begin : g_in
         evt_flag_bit #(.RST_VAL(FLAG_RST[i])) u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (set_vec[i]),
            .clr_i  (sw_clr[i] | bc_wr[in_port(i)]),
            .flag_o (flag_q[i])
         );
      end else begin : g_plain
         evt_flag_bit #(.RST_VAL(FLAG_RST[i])) u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (set_vec[i]),
            .clr_i  (sw_clr[i]),
            .flag_o (flag_q[i])
         );
      end
   end

   evt_enable_reg #(
      .N      (NUM_FLAGS),
      .ADDR_W (ADDR_W),
      .ADDR   (ENA_ADDR)
   ) u_ena (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (reg_wr),
      .addr_i  (reg_addr),
      .wdata_i (reg_wdata[NUM_FLAGS-1:0]),
      .ena_o   (ena_q)
   );

   evt_irq_reduce #(.N(NUM_FLAGS)) u_irq (
      .clk    (clk),
      .rst_n  (rst_n),
      .flag_i (flag_q),
      .ena_i  (ena_q),
      .irq_o  (irq)
   );

   always_comb begin
      reg_rdata = '0;
      if (reg_rd) begin
         if (reg_addr == ADDR_W'(FLAG_ADDR))     reg_rdata = {{RSVD_W{1'b0}}, flag_q};
         else if (reg_addr == ADDR_W'(ENA_ADDR)) reg_rdata = {{RSVD_W{1'b0}}, ena_q};
      end
   end
endmodule

// File: rtl/usb_ep_event_flags_chk.sv
module usb_ep_event_flags_chk #(
   parameter logic [4:0] FLAG_ADDR = 5'h07
) (
   input logic       clk,
   input logic       rst_n,
   input logic       ev_setup_ok,
   input logic [2:0] ev_in_ack,
   input logic [1:0] ev_out_ack,
   input logic [2:0] bc_wr,
   input logic [4:0] reg_addr,
   input logic       reg_wr,
   input logic [7:0] reg_wdata,
   input logic       reg_rd,
   input logic [7:0] reg_rdata,
   input logic [1:0] out_arm,
   input logic       irq,
   input logic [5:0] flag_q,
   input logic [5:0] ena_q
);
   logic hit_wr;
   assign hit_wr = reg_wr && (reg_addr == FLAG_ADDR);

   assert_setup_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ev_setup_ok |=> flag_q[5]);
   assert_in0_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ev_in_ack[0] |=> flag_q[0]);
   assert_out1_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ev_out_ack[1] |=> flag_q[2]);
   assert_out0_fall_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag_q[1]) |-> $past(hit_wr && reg_wdata[1]));
   assert_in2_fall_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag_q[3]) |-> $past((hit_wr && reg_wdata[3]) || bc_wr[1]));
   assert_setup_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q[5] && !(hit_wr && reg_wdata[5])) |=> flag_q[5]);
   assert_arm0_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
      out_arm[0] |-> $fell(flag_q[1]));
   assert_arm1_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      out_arm[1] |=> !out_arm[1]);
   assert_irq_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (|(flag_q & ena_q)) |=> irq);
   assert_irq_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(|(flag_q & ena_q)) |=> !irq);
   assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata[7:6] == 2'b00);
   assert_rd_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rd |-> (reg_rdata == 8'h00));
endmodule

bind usb_ep_event_flags usb_ep_event_flags_chk #(.FLAG_ADDR(FLAG_ADDR)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .ev_setup_ok (ev_setup_ok),
   .ev_in_ack   (ev_in_ack),
   .ev_out_ack  (ev_out_ack),
   .bc_wr       (bc_wr),
   .reg_addr    (reg_addr),
   .reg_wr      (reg_wr),
   .reg_wdata   (reg_wdata),
   .reg_rd      (reg_rd),
   .reg_rdata   (reg_rdata),
   .out_arm     (out_arm),
   .irq         (irq),
   .flag_q      (flag_q),
   .ena_q       (ena_q)
);

// File: tb/sim_usb_ep_event_flags.sv
module sim_usb_ep_event_flags;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ev_setup_ok = 1'b0;
   logic [2:0] ev_in_ack = '0;
   logic [1:0] ev_out_ack = '0;
   logic [2:0] bc_wr = '0;
   logic [4:0] reg_addr = '0;
   logic       reg_wr = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic       reg_rd = 1'b0;
   logic [7:0] reg_rdata;
   logic [1:0] out_arm;
   logic       irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   usb_ep_event_flags u0 (
      .clk(clk), .rst_n(rst_n), .ev_setup_ok(ev_setup_ok), .ev_in_ack(ev_in_ack),
      .ev_out_ack(ev_out_ack), .bc_wr(bc_wr), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
      .out_arm(out_arm), .irq(irq)
   );

   // vector: ev[25:20] (flag bit order), bc[19:17], wr[16], wdata[15:8], exp flags[7:2], exp arm[1:0]
   localparam int NV = 12;
   localparam logic [25:0] VEC [NV] = '{
      {6'b000000, 3'b000, 1'b0, 8'h00, 6'b011001, 2'b00}, // R4 hold
      {6'b000110, 3'b000, 1'b0, 8'h00, 6'b011111, 2'b00}, // R3 out sets
      {6'b100000, 3'b000, 1'b0, 8'h00, 6'b111111, 2'b00}, // R3 setup
      {6'b000000, 3'b000, 1'b1, 8'h00, 6'b111111, 2'b00}, // R5 zeros keep
      {6'b000000, 3'b000, 1'b1, 8'h02, 6'b111101, 2'b01}, // R5 R8 out0 clear
      {6'b000000, 3'b000, 1'b1, 8'hC4, 6'b111001, 2'b10}, // R5 R8 out1 clear
      {6'b000000, 3'b011, 1'b0, 8'h00, 6'b110000, 2'b00}, // R6 bc clears in0,in2
      {6'b000001, 3'b001, 1'b0, 8'h00, 6'b110001, 2'b00}, // R7 set beats bc
      {6'b000010, 3'b000, 1'b1, 8'h02, 6'b110011, 2'b00}, // R7 R8 set beats write, no arm
      {6'b000000, 3'b000, 1'b1, 8'h3F, 6'b000000, 2'b01}, // R5 R8 clear all
      {6'b000000, 3'b000, 1'b1, 8'h04, 6'b000000, 2'b00}, // R8 no arm when already 0
      {6'b011001, 3'b000, 1'b0, 8'h00, 6'b011001, 2'b00}  // R3 in sets
   };

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic read_reg(logic [4:0] a, output logic [7:0] d);
      reg_addr = a;
      reg_rd = 1'b1;
      #1;
      d = reg_rdata;
      reg_rd = 1'b0;
      reg_addr = '0;
      #1;
   endtask

   task automatic clear_inputs();
      ev_setup_ok = 1'b0; ev_in_ack = '0; ev_out_ack = '0; bc_wr = '0;
      reg_wr = 1'b0; reg_wdata = '0; reg_addr = '0;
   endtask

   task automatic write_reg(logic [4:0] a, logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_wr = 1'b1; reg_wdata = d;
      @(negedge clk);
      clear_inputs();
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      repeat (3) @(negedge clk);
      // reset state, R1
      read_reg(5'h07, d); check("R1 flags", d, 8'h19);
      read_reg(5'h08, d); check("R1 enable", d, 8'h00);
      check("R1 irq", irq, 1'b0);
      check("R1 arm", out_arm, 2'b00);
      rst_n = 1'b1;
      @(negedge clk);
      read_reg(5'h07, d); check("R1 flags after release", d, 8'h19);

      // table walk
      for (int v = 0; v < NV; v++) begin
         @(negedge clk);
         {ev_setup_ok, ev_in_ack[2], ev_in_ack[1], ev_out_ack[1], ev_out_ack[0], ev_in_ack[0]} = VEC[v][25:20];
         bc_wr = VEC[v][19:17];
         reg_wr = VEC[v][16];
         reg_wdata = VEC[v][15:8];
         reg_addr = 5'h07;
         @(negedge clk);
         clear_inputs();
         check($sformatf("R3/R5/R7 arm vec%0d R8", v), out_arm, VEC[v][1:0]);
         read_reg(5'h07, d);
         check($sformatf("R2 flags vec%0d", v), d, {2'b00, VEC[v][7:2]});
      end
      // flags now 0x19; arm pulse ended, R8
      @(negedge clk);
      check("R8 arm one cycle", out_arm, 2'b00);

      // R5 write elsewhere leaves flags
      write_reg(5'h05, 8'hFF);
      read_reg(5'h07, d); check("R5 other address", d, 8'h19);

      // R10 idle and unknown address
      reg_addr = 5'h07; #1; check("R10 rd low", reg_rdata, 8'h00); reg_addr = '0;
      read_reg(5'h1F, d); check("R10 unknown addr", d, 8'h00);

      // R2 enable readback masks reserved bits; irq timing R9
      write_reg(5'h08, 8'hFF);
      read_reg(5'h08, d); check("R2 enable readback", d, 8'h3F);
      check("R9 irq lags enable", irq, 1'b0);
      @(negedge clk);
      check("R9 irq high", irq, 1'b1);
      write_reg(5'h08, 8'h20);        // only setup enabled, setup flag is 0
      @(negedge clk);
      check("R9 irq low", irq, 1'b0);
      @(negedge clk);
      ev_setup_ok = 1'b1;
      @(negedge clk);
      ev_setup_ok = 1'b0;
      check("R9 irq not yet", irq, 1'b0);
      @(negedge clk);
      check("R9 irq after setup", irq, 1'b1);
      write_reg(5'h07, 8'h20);
      @(negedge clk);
      check("R9 irq drops after clear", irq, 1'b0);
      read_reg(5'h07, d); check("R4 others held", d, 8'h19);

      // R1 reset mid-run restores values
      write_reg(5'h07, 8'h3F);
      rst_n = 1'b0;
      #2;
      read_reg(5'h07, d); check("R1 re-reset flags", d, 8'h19);
      read_reg(5'h08, d); check("R1 re-reset enable", d, 8'h00);
      rst_n = 1'b1;

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule